// File: doc/BRIEF.md
# Translation Lock Arbiter

This block guards page-table invalidation against in-flight address translations. Any of `NREQ` translation requesters may take the lock with a one-cycle acquire strobe and give it back with a one-cycle release strobe. A separate invalidation agent announces its intent with its own strobe, waits until no translation holds the lock, owns it exclusively, and then hands it back. The shared control word has three parts: an exclusive bit, a holder count `CNT_W` bits wide, and a group bit that marks the invalidation side as waiting or owning. Every change to the word is one read-modify-write in a single cycle, as if done by an atomic compare-and-swap. Exactly one update happens per cycle.

The `mode_shared_i` input selects one of two locking disciplines. In simple mode the count is a nesting depth. Only the first acquire has to wait for the exclusive bit to be clear, and nested acquires always pass, even while the invalidation side is waiting. In shared mode the count is the number of holders. Every acquire waits while the group bit is set, so a pending invalidation drains the holders. In both modes the exclusive bit drops, and `wake_o` pulses, when the count returns to zero.

Control state machine. There are four states. `ST_FREE` means no holder and no group bit. `ST_HELD` means the count is nonzero and the group bit is clear. `ST_DRAIN` means the group bit is set and the invalidation side is waiting. `ST_INV` means the invalidation side owns the lock. The transitions are:
- `FREE`/`HELD` to `DRAIN` on an invalidation request.
- `FREE` to `HELD` on the first acquire.
- `HELD` to `FREE` when the last release brings the count to zero.
- `DRAIN` to `INV` when the count is zero (invalidation grant).
- `INV` to `FREE` on invalidation release.

Top module: `xlat_lock_arb`

## Requirements
- R1: After reset the count is 0, the exclusive and group bits are 0, `held_o` is 0, and no grant, wake or error pulse is present.
- R2: In simple mode, an acquire with count 0 and the exclusive bit clear is granted. An acquire with a nonzero count is granted even while the group bit is set. Each grant sets the exclusive bit and adds one to the count.
- R3: In simple mode, an acquire with count 0 is not granted while the exclusive bit is set (invalidation owns the lock). It stays pending and is granted the cycle after the invalidation release.
- R4: In shared mode, no acquire is granted while the group bit is set, even if the count is nonzero. Otherwise a grant sets the exclusive bit and adds one to the count in the same update.
- R5: A release subtracts one from the count. When the count reaches 0, the exclusive bit clears and `wake_o` pulses for one cycle. Releases that leave the count nonzero do not pulse `wake_o`.
- R6: `held_o` is 1 exactly when the count is nonzero.
- R7: Acquire and release strobes are held pending until served. One update is made per cycle. Among pending requesters, bit index 0 has the highest priority, and the grant is a one-hot pulse on `gnt_o`.
- R8: An acquire with the count at all ones is consumed without a grant, and the count stays. A release with count 0 changes nothing. Both pulse `cnt_err_o` for one cycle.
- R9: `inv_acq_i` in `ST_FREE` or `ST_HELD` sets the group bit. Once the count is 0, the next update pulses `inv_gnt_o` and sets the exclusive bit. `inv_rel_i` while owning clears both bits and pulses `wake_o`.
- R10: When several updates compete in one cycle, the order is: invalidation release, then requester release, then invalidation grant, then requester acquire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_shared_i | input | 1 | 1 selects shared mode, 0 selects simple mode; change only when the count is 0 |
| acq_req_i | input | NREQ | Per-requester acquire strobe |
| rel_req_i | input | NREQ | Per-requester release strobe |
| inv_acq_i | input | 1 | Invalidation-side acquire strobe |
| inv_rel_i | input | 1 | Invalidation-side release strobe |
| gnt_o | output | NREQ | One-hot grant pulse |
| inv_gnt_o | output | 1 | Invalidation grant pulse |
| wake_o | output | 1 | Pulse when the lock becomes free |
| cnt_err_o | output | 1 | Count overflow/underflow pulse |
| held_o | output | 1 | Count is nonzero |
| excl_o | output | 1 | Exclusive bit of the control word |
| grp_o | output | 1 | Group bit of the control word |
| hold_cnt_o | output | CNT_W | Holder / nesting count |

## Verification
A strobe that is present at a rising edge is acted on at that same edge if it wins arbitration. The grant, the wake and error pulses, and the new control word are all visible after that edge. The bench therefore drives at the falling edge and checks at the next falling edge. A request that loses arbitration moves exactly one cycle later for each update ahead of it. The checks count those cycles: a sweep over every acquire pattern expects the k-th lowest set bit to be granted k cycles after the strobe. The invalidation grant is expected one cycle after the count reaches zero, and a blocked acquire is expected one cycle after the invalidation release.

// File: rtl/xlat_lock_pkg.sv
package xlat_lock_pkg;

    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_HELD  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_INV   = 2'd3
    } lock_state_e;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_INV_REL = 3'd1,
        OP_REL     = 3'd2,
        OP_INV_GNT = 3'd3,
        OP_ACQ     = 3'd4
    } lock_op_e;

endpackage

// File: rtl/xlat_lock_pend.sv
module xlat_lock_pend #(
    parameter int NREQ = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] strobe_i,
    input  logic [NREQ-1:0] clr_i,
    output logic [NREQ-1:0] eff_o
);

    logic [NREQ-1:0] pend_q;

    for (genvar g = 0; g < NREQ; g++) begin : g_bit
        // a strobe counts in its own cycle; the pending bit carries it on
        assign eff_o[g] = pend_q[g] | strobe_i[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[g] <= 1'b0;
            end else begin
                pend_q[g] <= eff_o[g] & ~clr_i[g];
            end
        end
    end

endmodule

// File: rtl/xlat_lock_pick.sv
module xlat_lock_pick #(
    parameter int NREQ = 4
) (
    input  logic [NREQ-1:0] req_i,
    output logic [NREQ-1:0] sel_o
);

    logic [NREQ:0] seen;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < NREQ; g++) begin : g_chain
        assign sel_o[g]    = req_i[g] & ~seen[g];
        assign seen[g + 1] = seen[g] | req_i[g];
    end

endmodule

// File: rtl/xlat_lock_core.sv
module xlat_lock_core
    import xlat_lock_pkg::*;
#(
    parameter int NREQ  = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_shared_i,
    input  logic             inv_acq_i,
    input  logic             inv_rel_i,
    input  logic [NREQ-1:0]  acq_sel_i,
    input  logic [NREQ-1:0]  rel_sel_i,
    output logic [NREQ-1:0]  acq_clr_o,
    output logic [NREQ-1:0]  rel_clr_o,
    output logic [NREQ-1:0]  gnt_o,
    output logic             inv_gnt_o,
    output logic             wake_o,
    output logic             cnt_err_o,
    output logic             excl_o,
    output logic             grp_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    lock_state_e      state_q, state_d;
    lock_op_e         op;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             excl_q, excl_d;
    logic             grp_q, grp_d;
    logic [NREQ-1:0]  gnt_d;
    logic             inv_gnt_d, wake_d, err_d;
    logic             acq_any, rel_any, acq_ok, cnt_zero, cnt_full, grp_raise;

    assign acq_any  = |acq_sel_i;
    assign rel_any  = |rel_sel_i;
    assign cnt_zero = (cnt_q == '0);
    assign cnt_full = (cnt_q == CNT_MAX);

    // shared mode blocks on the group bit; simple mode only blocks a first acquire
    assign acq_ok = mode_shared_i ? !grp_q : (!cnt_zero || !excl_q);

    assign grp_raise = inv_acq_i && ((state_q == ST_FREE) || (state_q == ST_HELD));

    // one read-modify-write per cycle, fixed precedence
    always_comb begin
        op = OP_NONE;
        if (inv_rel_i && (state_q == ST_INV)) begin
            op = OP_INV_REL;
        end else if (rel_any) begin
            op = OP_REL;
        end else if ((state_q == ST_DRAIN) && cnt_zero) begin
            op = OP_INV_GNT;
        end else if (acq_any && acq_ok) begin
            op = OP_ACQ;
        end
    end

    assign acq_clr_o = (op == OP_ACQ) ? acq_sel_i : '0;
    assign rel_clr_o = (op == OP_REL) ? rel_sel_i : '0;

    // control word update
    always_comb begin
        cnt_d     = cnt_q;
        excl_d    = excl_q;
        grp_d     = grp_q;
        gnt_d     = '0;
        inv_gnt_d = 1'b0;
        wake_d    = 1'b0;
        err_d     = 1'b0;
        unique case (op)
            OP_INV_REL: begin
                grp_d  = 1'b0;
                excl_d = 1'b0;
                wake_d = 1'b1;
            end
            OP_REL: begin
                if (cnt_zero) begin
                    err_d = 1'b1;
                end else begin
                    cnt_d = cnt_q - CNT_ONE;
                    if (cnt_q == CNT_ONE) begin
                        excl_d = 1'b0;
                        wake_d = 1'b1;
                    end
                end
            end
            OP_INV_GNT: begin
                excl_d    = 1'b1;
                inv_gnt_d = 1'b1;
            end
            OP_ACQ: begin
                if (cnt_full) begin
                    err_d = 1'b1;
                end else begin
                    cnt_d  = cnt_q + CNT_ONE;
                    excl_d = 1'b1;
                    gnt_d  = acq_sel_i;
                end
            end
            default: begin
            end
        endcase
        if (grp_raise) begin
            grp_d = 1'b1;
        end
    end

    // state transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE, ST_HELD: begin
                if (grp_d) begin
                    state_d = ST_DRAIN;
                end else if (cnt_d != '0) begin
                    state_d = ST_HELD;
                end else begin
                    state_d = ST_FREE;
                end
            end
            ST_DRAIN: begin
                if (op == OP_INV_GNT) begin
                    state_d = ST_INV;
                end
            end
            ST_INV: begin
                if (op == OP_INV_REL) begin
                    state_d = ST_FREE;
                end
            end
        endcase
    end

    // state register and control word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
            cnt_q   <= '0;
            excl_q  <= 1'b0;
            grp_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            excl_q  <= excl_d;
            grp_q   <= grp_d;
        end
    end

    // registered pulse outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gnt_o     <= '0;
            inv_gnt_o <= 1'b0;
            wake_o    <= 1'b0;
            cnt_err_o <= 1'b0;
        end else begin
            gnt_o     <= gnt_d;
            inv_gnt_o <= inv_gnt_d;
            wake_o    <= wake_d;
            cnt_err_o <= err_d;
        end
    end

    assign excl_o = excl_q;
    assign grp_o  = grp_q;
    assign cnt_o  = cnt_q;

endmodule

// File: rtl/xlat_lock_arb.sv
module xlat_lock_arb #(
    parameter int NREQ  = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_shared_i,
    input  logic [NREQ-1:0]  acq_req_i,
    input  logic [NREQ-1:0]  rel_req_i,
    input  logic             inv_acq_i,
    input  logic             inv_rel_i,
    output logic [NREQ-1:0]  gnt_o,
    output logic             inv_gnt_o,
    output logic             wake_o,
    output logic             cnt_err_o,
    output logic             held_o,
    output logic             excl_o,
    output logic             grp_o,
    output logic [CNT_W-1:0] hold_cnt_o
);

    logic [NREQ-1:0] acq_eff, rel_eff, acq_sel, rel_sel, acq_clr, rel_clr;

    xlat_lock_pend #(.NREQ(NREQ)) acq_pend_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (acq_req_i),
        .clr_i    (acq_clr),
        .eff_o    (acq_eff)
    );

    xlat_lock_pend #(.NREQ(NREQ)) rel_pend_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (rel_req_i),
        .clr_i    (rel_clr),
        .eff_o    (rel_eff)
    );

    xlat_lock_pick #(.NREQ(NREQ)) acq_pick_i (
        .req_i (acq_eff),
        .sel_o (acq_sel)
    );

    xlat_lock_pick #(.NREQ(NREQ)) rel_pick_i (
        .req_i (rel_eff),
        .sel_o (rel_sel)
    );

    xlat_lock_core #(.NREQ(NREQ), .CNT_W(CNT_W)) core_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_shared_i (mode_shared_i),
        .inv_acq_i     (inv_acq_i),
        .inv_rel_i     (inv_rel_i),
        .acq_sel_i     (acq_sel),
        .rel_sel_i     (rel_sel),
        .acq_clr_o     (acq_clr),
        .rel_clr_o     (rel_clr),
        .gnt_o         (gnt_o),
        .inv_gnt_o     (inv_gnt_o),
        .wake_o        (wake_o),
        .cnt_err_o     (cnt_err_o),
        .excl_o        (excl_o),
        .grp_o         (grp_o),
        .cnt_o         (hold_cnt_o)
    );

    assign held_o = (hold_cnt_o != '0);

endmodule

// File: rtl/xlat_lock_chk.sv
module xlat_lock_chk #(
    parameter int NREQ  = 4,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_shared_i,
    input logic [NREQ-1:0]  gnt_o,
    input logic             inv_gnt_o,
    input logic             wake_o,
    input logic             excl_o,
    input logic             grp_o,
    input logic [CNT_W-1:0] hold_cnt_o
);

    // R7: never more than one requester granted per cycle
    a_r7_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R2/R4: every grant raises the count by exactly one
    a_r2_grant_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt_o) |-> (hold_cnt_o == CNT_W'($past(hold_cnt_o) + 1'b1)));

    // R4: shared mode grants nothing while the group bit was set
    a_r4_group_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_shared_i) && $past(grp_o)) |-> (gnt_o == '0));

    // R5: a falling exclusive bit comes with a wake pulse
    a_r5_wake_on_free: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(excl_o) |-> wake_o);

    // R8: the count never wraps in either direction
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hold_cnt_o) == {CNT_W{1'b1}}) |-> (hold_cnt_o != '0));

    a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hold_cnt_o) == '0) |-> (hold_cnt_o != {CNT_W{1'b1}}));

    // R9: the invalidation side is granted only with no holder left
    a_r9_inv_alone: assert property (@(posedge clk) disable iff (!rst_n)
        inv_gnt_o |-> (hold_cnt_o == '0 && excl_o && grp_o));

endmodule

bind xlat_lock_arb xlat_lock_chk #(.NREQ(NREQ), .CNT_W(CNT_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_shared_i (mode_shared_i),
    .gnt_o         (gnt_o),
    .inv_gnt_o     (inv_gnt_o),
    .wake_o        (wake_o),
    .excl_o        (excl_o),
    .grp_o         (grp_o),
    .hold_cnt_o    (hold_cnt_o)
);

// File: tb/xlat_lock_arb_tb.sv
module xlat_lock_arb_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NREQ       = 4;
    localparam int CNT_W      = 8;
    localparam int CNT_MAX    = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_shared = 1'b0;
    logic [NREQ-1:0]  acq_req = '0;
    logic [NREQ-1:0]  rel_req = '0;
    logic             inv_acq = 1'b0;
    logic             inv_rel = 1'b0;
    logic [NREQ-1:0]  gnt;
    logic             inv_gnt, wake, cnt_err, held, excl, grp;
    logic [CNT_W-1:0] hold_cnt;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xlat_lock_arb #(.NREQ(NREQ), .CNT_W(CNT_W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_shared_i (mode_shared),
        .acq_req_i     (acq_req),
        .rel_req_i     (rel_req),
        .inv_acq_i     (inv_acq),
        .inv_rel_i     (inv_rel),
        .gnt_o         (gnt),
        .inv_gnt_o     (inv_gnt),
        .wake_o        (wake),
        .cnt_err_o     (cnt_err),
        .held_o        (held),
        .excl_o        (excl),
        .grp_o         (grp),
        .hold_cnt_o    (hold_cnt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive strobes for one rising edge; outputs then reflect that edge
    task automatic step(input logic [NREQ-1:0] a, input logic [NREQ-1:0] r,
                        input logic ia, input logic ir);
        acq_req = a;
        rel_req = r;
        inv_acq = ia;
        inv_rel = ir;
        @(posedge clk);
        @(negedge clk);
        acq_req = '0;
        rel_req = '0;
        inv_acq = 1'b0;
        inv_rel = 1'b0;
    endtask

    function automatic int nth_set(input logic [NREQ-1:0] pat, input int n);
        int seen = 0;
        for (int b = 0; b < NREQ; b++) begin
            if (pat[b]) begin
                if (seen == n) return b;
                seen++;
            end
        end
        return -1;
    endfunction

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 count", int'(hold_cnt), 0);
        chk("R1 excl", int'(excl), 0);
        chk("R1 grp", int'(grp), 0);
        chk("R1 held", int'(held), 0);
        chk("R1 pulses", int'({gnt, inv_gnt, wake, cnt_err}), 0);

        // R7/R4/R5/R6 shared-mode sweep over every acquire pattern
        mode_shared = 1'b1;
        for (int p = 1; p < (1 << NREQ); p++) begin
            logic [NREQ-1:0] pat;
            int pc;
            pat = NREQ'(p);
            pc  = $countones(pat);
            for (int k = 0; k < pc; k++) begin
                if (k == 0) step(pat, '0, 1'b0, 1'b0);
                else        step('0, '0, 1'b0, 1'b0);
                chk("R7 grant order", int'(gnt), 1 << nth_set(pat, k));
                chk("R4 count up", int'(hold_cnt), k + 1);
                chk("R6 held", int'(held), 1);
                chk("R4 excl set", int'(excl), 1);
            end
            step('0, '0, 1'b0, 1'b0);
            chk("R7 no extra grant", int'(gnt), 0);
            for (int k = 0; k < pc; k++) begin
                if (k == 0) step('0, pat, 1'b0, 1'b0);
                else        step('0, '0, 1'b0, 1'b0);
                chk("R5 count down", int'(hold_cnt), pc - k - 1);
                chk("R5 wake", int'(wake), (k == pc - 1) ? 1 : 0);
                chk("R6 held", int'(held), (k == pc - 1) ? 0 : 1);
            end
            chk("R5 excl cleared", int'(excl), 0);
        end

        // R4/R9/R10 shared mode drain by invalidation side
        step(4'b0001, '0, 1'b0, 1'b0);
        step('0, '0, 1'b1, 1'b0);
        chk("R9 group set", int'(grp), 1);
        step(4'b0010, '0, 1'b0, 1'b0);
        chk("R4 blocked by group", int'(gnt), 0);
        chk("R4 count held", int'(hold_cnt), 1);
        step('0, 4'b0001, 1'b0, 1'b0);
        chk("R5 last release wake", int'(wake), 1);
        chk("R9 no early inv grant", int'(inv_gnt), 0);
        step('0, '0, 1'b0, 1'b0);
        chk("R9 inv grant", int'(inv_gnt), 1);
        chk("R9 excl by inv", int'(excl), 1);
        chk("R4 still blocked", int'(gnt), 0);
        step('0, '0, 1'b0, 1'b1);
        chk("R9 inv release wake", int'(wake), 1);
        chk("R9 grp cleared", int'(grp), 0);
        chk("R10 no acquire on inv release", int'(gnt), 0);
        step('0, '0, 1'b0, 1'b0);
        chk("R4 pending granted", int'(gnt), 2);
        step('0, 4'b0010, 1'b0, 1'b0);
        chk("R5 back to zero", int'(hold_cnt), 0);

        // R2/R3 simple mode nesting past a waiting invalidation
        mode_shared = 1'b0;
        step(4'b0100, '0, 1'b0, 1'b0);
        chk("R2 first grant", int'(gnt), 4);
        step('0, '0, 1'b1, 1'b0);
        step(4'b1000, '0, 1'b0, 1'b0);
        chk("R2 nested grant despite group", int'(gnt), 8);
        chk("R2 nested count", int'(hold_cnt), 2);
        step('0, 4'b0100, 1'b0, 1'b0);
        chk("R5 no wake while nested", int'(wake), 0);
        step('0, 4'b1000, 1'b0, 1'b0);
        chk("R5 simple wake", int'(wake), 1);
        step('0, '0, 1'b0, 1'b0);
        chk("R9 simple inv grant", int'(inv_gnt), 1);
        step(4'b0001, '0, 1'b0, 1'b0);
        chk("R3 blocked by excl", int'(gnt), 0);
        step('0, '0, 1'b0, 1'b0);
        chk("R3 still blocked", int'(gnt), 0);
        step('0, '0, 1'b0, 1'b1);
        chk("R3 wake on inv release", int'(wake), 1);
        step('0, '0, 1'b0, 1'b0);
        chk("R3 granted after release", int'(gnt), 1);
        chk("R3 excl set", int'(excl), 1);

        // R10 release wins over acquire in the same cycle
        step(4'b0010, 4'b0001, 1'b0, 1'b0);
        chk("R10 release first", int'(hold_cnt), 0);
        chk("R10 acquire waits", int'(gnt), 0);
        step('0, '0, 1'b0, 1'b0);
        chk("R10 acquire next cycle", int'(gnt), 2);
        step('0, 4'b0010, 1'b0, 1'b0);

        // R8 underflow
        step('0, 4'b0001, 1'b0, 1'b0);
        chk("R8 underflow err", int'(cnt_err), 1);
        chk("R8 underflow count", int'(hold_cnt), 0);
        chk("R8 underflow no wake", int'(wake), 0);

        // R8 overflow in shared mode
        mode_shared = 1'b1;
        begin
            int miss = 0;
            for (int k = 0; k < CNT_MAX; k++) begin
                step(4'b0001, '0, 1'b0, 1'b0);
                if (gnt != 4'b0001 || int'(hold_cnt) != k + 1) miss++;
            end
            chk("R8 fill grants", miss, 0);
        end
        step(4'b0001, '0, 1'b0, 1'b0);
        chk("R8 overflow err", int'(cnt_err), 1);
        chk("R8 overflow no grant", int'(gnt), 0);
        chk("R8 saturated", int'(hold_cnt), CNT_MAX);
        step('0, '0, 1'b0, 1'b0);
        chk("R8 request consumed", int'(gnt), 0);
        begin
            int miss = 0;
            for (int k = 0; k < CNT_MAX; k++) begin
                step('0, 4'b0001, 1'b0, 1'b0);
                if (int'(hold_cnt) != CNT_MAX - k - 1) miss++;
            end
            chk("R8 drain count", miss, 0);
        end
        chk("R5 wake after drain", int'(wake), 1);
        chk("R6 released", int'(held), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule